// File: doc/BRIEF.md
# Two-Door Card and Keypad Access Controller

This block grants or refuses entry through two doors. A card reader supplies a 2-bit code that says whether a card is present and, if so, which door it belongs to. A keypad supplies a 3-bit code that the holder must already be pressing when the card goes in. The block turns these two codes into three outputs: an unlock line for each door and a shared alarm line.

A decision is taken once per card insertion. The insertion is the first rising clock edge at which the card code is no longer the empty code. On that edge the block samples both codes and computes a verdict. It then holds that verdict until a clock edge at which the card code reads empty again. Keypad changes during an insertion do not alter the verdict. A switch between non-empty card codes without an empty code in between does not alter it either. Each door has its own pair of accepted keypad codes, and one code is accepted by both doors.

The inputs are sampled level signals and the outputs are plain control lines. There is no payload to transfer, so the block has no valid/ready handshake and applies no back-pressure. The card code returning to empty is the only way to end a decision.

Top module: `door_access_ctrl`

## Requirements
- R1: The card code is decoded as follows: 2'b00 means no card, 2'b01 is a card for door 1, 2'b11 is a card for door 2, and 2'b10 is an invalid card.
- R2: On insertion of a door-1 card with keypad 3'b101 or 3'b110, only `unlock_d1` asserts.
- R3: On insertion of a door-2 card with keypad 3'b101 or 3'b011, only `unlock_d2` asserts.
- R4: On insertion of an invalid card, only `alarm` asserts, whatever the keypad code.
- R5: On insertion of a valid card whose keypad code is not accepted by that card's door, only `alarm` asserts.
- R6: Both codes are sampled on the rising edge at which the card code first differs from 2'b00. The verdict appears on the outputs right after that edge.
- R7: While the card code stays non-zero, the outputs hold the insertion verdict. Keypad changes and changes between non-zero card codes are ignored.
- R8: After any rising edge at which the card code is 2'b00, all three outputs are low.
- R9: At most one of `unlock_d1`, `unlock_d2` and `alarm` is high at any time.
- R10: A synchronous active-high reset clears all outputs. If a non-zero card code is present on the first edge after reset, that edge counts as an insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| card_code | input | 2 | Card-reader code (see R1) |
| key_code | input | 3 | Keypad code held by the user |
| unlock_d1 | output | 1 | Unlock command for door 1 |
| unlock_d2 | output | 1 | Unlock command for door 2 |
| alarm | output | 1 | Alarm request |

## Verification
The bench builds the block with its default parameters: 2-bit card codes, 3-bit keypad codes and two accepted codes per door. At that size all 32 card/keypad pairs can be tried as separate insertions, so every accept and refuse path and the shared code 3'b101 are covered for both doors. Directed sequences also change the keypad or the card code in the middle of an insertion, and assert reset while a card is held, to check the hold and re-insertion rules.

// File: rtl/door_access_pkg.sv
package door_access_pkg;
  localparam int NUM_DOORS = 2;

  typedef enum logic [1:0] {
    CARD_NONE = 2'd0,
    CARD_D1   = 2'd1,
    CARD_D2   = 2'd2,
    CARD_BAD  = 2'd3
  } card_kind_e;

  typedef struct packed {
    logic unlock1;
    logic unlock2;
    logic alarm;
  } verdict_t;
endpackage

// File: rtl/card_decoder.sv
module card_decoder
  import door_access_pkg::*;
#(
  parameter int               CARD_W    = 2,
  parameter logic [CARD_W-1:0] CODE_NONE = 2'b00,
  parameter logic [CARD_W-1:0] CODE_D1   = 2'b01,
  parameter logic [CARD_W-1:0] CODE_D2   = 2'b11
) (
  input  logic [CARD_W-1:0] card_code,
  output card_kind_e        kind
);
  always_comb begin
    if (card_code == CODE_NONE)    kind = CARD_NONE;
    else if (card_code == CODE_D1) kind = CARD_D1;
    else if (card_code == CODE_D2) kind = CARD_D2;
    else                           kind = CARD_BAD;
  end
endmodule

// File: rtl/key_matcher.sv
module key_matcher #(
  parameter int                        KEY_W   = 3,
  parameter int                        N_CODES = 2,
  parameter logic [N_CODES*KEY_W-1:0]  CODES   = {3'b110, 3'b101}
) (
  input  logic [KEY_W-1:0] key_code,
  output logic             match
);
  logic [N_CODES-1:0] hit;

  for (genvar i = 0; i < N_CODES; i++) begin : g_code
    assign hit[i] = (key_code == CODES[i*KEY_W +: KEY_W]);
  end

  assign match = |hit;
endmodule

// File: rtl/access_judge.sv
module access_judge
  import door_access_pkg::*;
(
  input  card_kind_e             kind,
  input  logic [NUM_DOORS-1:0]   door_ok,
  output verdict_t               verdict
);
  always_comb begin
    verdict = '0;
    unique case (kind)
      CARD_NONE: verdict = '0;
      CARD_D1: begin
        verdict.unlock1 = door_ok[0];
        verdict.alarm   = ~door_ok[0];
      end
      CARD_D2: begin
        verdict.unlock2 = door_ok[1];
        verdict.alarm   = ~door_ok[1];
      end
      default: verdict.alarm = 1'b1;
    endcase
  end
endmodule

// File: rtl/verdict_hold.sv
module verdict_hold
  import door_access_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     present,
  input  verdict_t next_verdict,
  output verdict_t held
);
  logic present_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= 1'b0;
      held      <= '0;
    end else if (!present) begin
      present_q <= 1'b0;
      held      <= '0;
    end else if (!present_q) begin
      present_q <= 1'b1;
      held      <= next_verdict;
    end
  end
endmodule

// File: rtl/door_access_ctrl.sv
module door_access_ctrl
  import door_access_pkg::*;
#(
  parameter int                CARD_W       = 2,
  parameter int                KEY_W        = 3,
  parameter int                N_CODES      = 2,
  parameter logic [CARD_W-1:0] CODE_NONE    = 2'b00,
  parameter logic [CARD_W-1:0] CODE_D1      = 2'b01,
  parameter logic [CARD_W-1:0] CODE_D2      = 2'b11,
  parameter logic [N_CODES*KEY_W-1:0] D1_KEYS = {3'b110, 3'b101},
  parameter logic [N_CODES*KEY_W-1:0] D2_KEYS = {3'b011, 3'b101}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CARD_W-1:0] card_code,
  input  logic [KEY_W-1:0]  key_code,
  output logic              unlock_d1,
  output logic              unlock_d2,
  output logic              alarm
);
  localparam int KEYSET_W = N_CODES * KEY_W;
  localparam logic [NUM_DOORS*KEYSET_W-1:0] ALL_KEYS = {D2_KEYS, D1_KEYS};

  card_kind_e           kind;
  logic [NUM_DOORS-1:0] door_ok;
  verdict_t             next_verdict;
  verdict_t             held;

  card_decoder #(
    .CARD_W(CARD_W), .CODE_NONE(CODE_NONE), .CODE_D1(CODE_D1), .CODE_D2(CODE_D2)
  ) u_dec (
    .card_code(card_code),
    .kind     (kind)
  );

  for (genvar d = 0; d < NUM_DOORS; d++) begin : g_door
    key_matcher #(
      .KEY_W(KEY_W), .N_CODES(N_CODES),
      .CODES(ALL_KEYS[d*KEYSET_W +: KEYSET_W])
    ) u_match (
      .key_code(key_code),
      .match   (door_ok[d])
    );
  end

  access_judge u_judge (
    .kind   (kind),
    .door_ok(door_ok),
    .verdict(next_verdict)
  );

  verdict_hold u_hold (
    .clk         (clk),
    .rst         (rst),
    .present     (kind != CARD_NONE),
    .next_verdict(next_verdict),
    .held        (held)
  );

  assign unlock_d1 = held.unlock1;
  assign unlock_d2 = held.unlock2;
  assign alarm     = held.alarm;
endmodule

// File: rtl/door_access_ctrl_chk.sv
module door_access_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] card_code,
  input logic [2:0] key_code,
  input logic       unlock_d1,
  input logic       unlock_d2,
  input logic       alarm
);
  logic chk_prev_nz;

  always_ff @(posedge clk) begin
    if (rst) chk_prev_nz <= 1'b0;
    else     chk_prev_nz <= (card_code != 2'b00);
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> ({unlock_d1, unlock_d2, alarm} == 3'b000));

  p_single_out_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({unlock_d1, unlock_d2, alarm}) <= 1);

  p_empty_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (card_code == 2'b00) |=> ({unlock_d1, unlock_d2, alarm} == 3'b000));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (card_code != 2'b00 && chk_prev_nz) |=> $stable({unlock_d1, unlock_d2, alarm}));

  p_bad_card_r4: assert property (@(posedge clk) disable iff (rst)
    (card_code == 2'b10 && !chk_prev_nz) |=> (alarm && !unlock_d1 && !unlock_d2));

  p_door1_open_r2: assert property (@(posedge clk) disable iff (rst)
    (card_code == 2'b01 && !chk_prev_nz && (key_code == 3'b101 || key_code == 3'b110))
      |=> unlock_d1);

  p_door2_open_r3: assert property (@(posedge clk) disable iff (rst)
    (card_code == 2'b11 && !chk_prev_nz && (key_code == 3'b101 || key_code == 3'b011))
      |=> unlock_d2);
endmodule

bind door_access_ctrl door_access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .card_code(card_code), .key_code(key_code),
  .unlock_d1(unlock_d1), .unlock_d2(unlock_d2), .alarm(alarm)
);

// File: tb/door_access_ctrl_tb_top.sv
module door_access_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] card_code = 2'b00;
  logic [2:0] key_code = 3'b000;
  logic       unlock_d1, unlock_d2, alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_prev = 0;
  int m_out = 0;

  always #4 clk = ~clk;

  door_access_ctrl dut_i (
    .clk(clk), .rst(rst), .card_code(card_code), .key_code(key_code),
    .unlock_d1(unlock_d1), .unlock_d2(unlock_d2), .alarm(alarm)
  );

  function automatic int expect_for(input int card, input int key);
    if (card == 0) return 0;
    if (card == 2) return 1;
    if (card == 1) return (key == 5 || key == 6) ? 4 : 1;
    return (key == 5 || key == 3) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev <= 0; m_out <= 0;
    end else if (card_code == 2'b00) begin
      m_prev <= 0; m_out <= 0;
    end else if (m_prev == 0) begin
      m_prev <= 1; m_out <= expect_for(int'(card_code), int'(key_code));
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if ({unlock_d1, unlock_d2, alarm} != 3'(m_out)) begin
        failures++;
        $display("FAIL R6 model compare: actual=%b expected=%b at %0t",
                 {unlock_d1, unlock_d2, alarm}, 3'(m_out), $time);
      end
      checks++;
      if ((int'(unlock_d1) + int'(unlock_d2) + int'(alarm)) > 1) begin
        failures++;
        $display("FAIL R9 several outputs high: actual=%b expected at most one",
                 {unlock_d1, unlock_d2, alarm});
      end
    end
  end

  task automatic step(input logic [1:0] c, input logic [2:0] k);
    card_code = c;
    key_code  = k;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({unlock_d1, unlock_d2, alarm} != exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, {unlock_d1, unlock_d2, alarm}, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", 3'b000);
    rst = 1'b0;
    step(2'b00, 3'b101); check("R8 idle", 3'b000);
    step(2'b01, 3'b101); check("R2 door1 shared code", 3'b100);
    check("R6 verdict after insertion edge", 3'b100);
    step(2'b01, 3'b000); check("R7 keypad change ignored", 3'b100);
    step(2'b11, 3'b000); check("R7 card change ignored", 3'b100);
    step(2'b00, 3'b000); check("R8 removal clears", 3'b000);
    step(2'b01, 3'b110); check("R2 door1 second code", 3'b100);
    step(2'b00, 3'b011);
    step(2'b01, 3'b011); check("R5 door1 wrong key", 3'b001);
    step(2'b00, 3'b011);
    step(2'b11, 3'b011); check("R3 door2 own code", 3'b010);
    step(2'b00, 3'b101);
    step(2'b11, 3'b101); check("R3 door2 shared code", 3'b010);
    step(2'b00, 3'b110);
    step(2'b11, 3'b110); check("R5 door2 wrong key", 3'b001);
    step(2'b00, 3'b101);
    step(2'b10, 3'b101); check("R4 invalid card", 3'b001);
    step(2'b10, 3'b110); check("R7 hold alarm", 3'b001);
    step(2'b00, 3'b000);
    step(2'b10, 3'b000); check("R4 invalid card any key", 3'b001);
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 8; k++) begin
        step(2'b00, 3'(k));
        step(2'(c), 3'(k));
        check("R1 code sweep", 3'(expect_for(c, k)));
      end
    end
    step(2'b00, 3'b101);
    step(2'b01, 3'b101); check("R2 before reset", 3'b100);
    rst = 1'b1;
    @(negedge clk); check("R10 reset while inserted", 3'b000);
    rst = 1'b0;
    @(negedge clk); check("R10 reinsertion after reset", 3'b100);
    step(2'b00, 3'b000); check("R8 final removal", 3'b000);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule